// File: doc/BRIEF.md
# Stride Prefetch Table with Confidence Tracking

This block learns constant-stride access patterns from load misses and turns them into prefetch addresses. Each training event carries a miss address, the address of the load instruction that missed, and a requester ID. The instruction address picks an entry in a small table. Each entry keeps four things: the instruction address, the last block address seen, a signed stride and a saturating confidence counter. A training event that finds its entry refines the stride and the confidence. Once the confidence reaches a programmable threshold, the block issues a run of addresses that continue the stride.

A training event that finds no entry allocates one in place of a free entry or the least confident entry. That event produces no prefetches. The table can be split into one bank per requester, so that two requesters never train each other's entries. An optional page stop ends a run at the first address that leaves the page of the triggering miss. The addresses that were not issued are added to a running span counter.

Prefetch addresses leave on a valid/ready stream. While a run is being issued, the training input is held off through its ready signal.

Top module: `stride_prefetch_table`

## Requirements
- R1: The miss address is aligned down to the block size by clearing its low BLK_LG bits. All stride arithmetic and every emitted address use the aligned value, so emitted addresses always have those bits at zero.
- R2: A training event hits when a valid entry in the selected bank holds an instruction address equal to `trainPc`. If more than one entry matches, the lowest-indexed entry is used.
- R3: On a hit, the new stride is the aligned address minus the stored last address. If the new stride equals the stored stride, confidence rises by one and saturates at 2^CONF_W-1. Otherwise the stored stride is replaced by the new stride and confidence falls by one, saturating at 0. In both cases the stored last address becomes the aligned address.
- R4: After a hit whose updated confidence is at or above `cfgThreshold`, the block emits the aligned address plus d times the stride, for d = 1 up to `cfgDegree`, in increasing d. The degree is captured at the training handshake. A degree of 0, a confidence below the threshold, or a table miss emits nothing.
- R5: `pfValid` holds with a stable `pfAddr` until `pfReady` is seen. `trainReady` is low from the cycle after an accepted training event until its run is finished, and it is never high while `pfValid` is high.
- R6: With `cfgPageStop` set, a run ends at the first address whose page (the bits above PAGE_LG) differs from the page of the aligned miss address. That address is not emitted, and degree - d + 1 is added to `spanCount`. With `cfgPageStop` clear, runs cross pages freely and `spanCount` is unchanged.
- R7: A training miss allocates an entry in the selected bank. The lowest-indexed invalid entry is used if one exists. Otherwise the entry with the lowest confidence is used, with ties going to the lowest index. The new entry holds `trainPc`, last address = the aligned address, stride 0 and confidence 0.
- R8: With `cfgPerRequester` set, the bank is selected by `trainId`. With it clear, bank 0 is used for every event. Entries in one bank never match events sent to another bank.
- R9: After reset every entry is invalid, `spanCount` is 0, `pfValid` is low and `trainReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trainValid | input | 1 | Training event offered |
| trainReady | output | 1 | Block can accept a training event |
| trainAddr | input | ADDR_W | Miss byte address |
| trainPc | input | PC_W | Instruction address of the missing load |
| trainId | input | ID_W | Requester ID |
| cfgPerRequester | input | 1 | Select the bank by requester ID |
| cfgPageStop | input | 1 | End runs at page crossings |
| cfgDegree | input | DEG_W | Maximum prefetches per run |
| cfgThreshold | input | CONF_W | Minimum confidence to emit |
| pfValid | output | 1 | Prefetch address valid |
| pfReady | input | 1 | Consumer accepts the prefetch |
| pfAddr | output | ADDR_W | Prefetch block address |
| spanCount | output | CNT_W | Running count of prefetches dropped at page stops |

## Verification
The bench builds the block with four entries per bank, two banks, a two-bit confidence counter, 64-byte blocks and 512-byte pages. Degrees up to 7 are used.

With pages of only eight blocks, page crossings in both directions occur within a few strides. The two-bit counter reaches saturation at both ends in a handful of events. Six instruction addresses share four entries, so replacement by least confidence, with its tie rule, occurs again and again under random strides and random backpressure.

// File: rtl/spt_pkg.sv
package spt_pkg;

  typedef struct packed {
    logic load;     // capture a training event, update the table
    logic step;     // advance to the next prefetch address
    logic spanAdd;  // run cut by a page stop, add remaining count
  } sptStrobes_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } sptState_t;

endpackage

// File: rtl/spt_victim.sv
module spt_victim #(
  parameter int ENTRIES = 4,
  parameter int CONF_W  = 2,
  parameter int IDX_W   = 2
) (
  input  logic [ENTRIES-1:0]        entValid,
  input  logic [ENTRIES*CONF_W-1:0] entConf,
  output logic [IDX_W-1:0]          victIdx
);

  logic              foundFree;
  logic [CONF_W-1:0] bestConf;

  always_comb begin
    foundFree = 1'b0;
    victIdx   = '0;
    bestConf  = entConf[CONF_W-1:0];
    for (int i = 0; i < ENTRIES; i++) begin
      if (!entValid[i] && !foundFree) begin
        foundFree = 1'b1;
        victIdx   = IDX_W'(i);
      end
    end
    if (!foundFree) begin
      for (int i = 1; i < ENTRIES; i++) begin
        if (entConf[i*CONF_W +: CONF_W] < bestConf) begin
          bestConf = entConf[i*CONF_W +: CONF_W];
          victIdx  = IDX_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/spt_datapath.sv
module spt_datapath
  import spt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PC_W    = 32,
  parameter int ID_W    = 1,
  parameter int ENTRIES = 4,
  parameter int CONF_W  = 2,
  parameter int DEG_W   = 3,
  parameter int BLK_LG  = 6,
  parameter int PAGE_LG = 12,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sptStrobes_t       strb,
  input  logic [DEG_W-1:0]  remain,
  input  logic [ADDR_W-1:0] trainAddr,
  input  logic [PC_W-1:0]   trainPc,
  input  logic [ID_W-1:0]   trainId,
  input  logic              cfgPerRequester,
  input  logic              cfgPageStop,
  input  logic [CONF_W-1:0] cfgThreshold,
  output logic              emitOk,
  output logic              crossPage,
  output logic [ADDR_W-1:0] pfAddr,
  output logic [CNT_W-1:0]  spanCount
);

  localparam int BANKS = 1 << ID_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << BLK_LG) - ADDR_W'(1));
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  logic [ENTRIES-1:0] tabValid  [BANKS];
  logic [PC_W-1:0]    tabPc     [BANKS][ENTRIES];
  logic [ADDR_W-1:0]  tabLast   [BANKS][ENTRIES];
  logic [ADDR_W-1:0]  tabStride [BANKS][ENTRIES];
  logic [CONF_W-1:0]  tabConf   [BANKS][ENTRIES];

  logic [ID_W-1:0]           bankSel;
  logic [ADDR_W-1:0]         blkAddr;
  logic                      hit;
  logic [IDX_W-1:0]          hitIdx;
  logic [IDX_W-1:0]          victIdx;
  logic [ENTRIES*CONF_W-1:0] bankConf;
  logic [ADDR_W-1:0]         newStride;
  logic                      sameStride;
  logic [CONF_W-1:0]         curConf;
  logic [CONF_W-1:0]         nextConf;

  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] strideReg;
  logic [ADDR_W-1:0] curAddr;

  assign bankSel = cfgPerRequester ? trainId : '0;
  assign blkAddr = trainAddr & BLK_MASK;

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (tabValid[bankSel][i] && tabPc[bankSel][i] == trainPc) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gConfFlat
    assign bankConf[g*CONF_W +: CONF_W] = tabConf[bankSel][g];
  end

  spt_victim #(
    .ENTRIES(ENTRIES),
    .CONF_W (CONF_W),
    .IDX_W  (IDX_W)
  ) u_victim (
    .entValid(tabValid[bankSel]),
    .entConf (bankConf),
    .victIdx (victIdx)
  );

  assign newStride  = blkAddr - tabLast[bankSel][hitIdx];
  assign sameStride = (newStride == tabStride[bankSel][hitIdx]);
  assign curConf    = tabConf[bankSel][hitIdx];

  always_comb begin
    if (sameStride) nextConf = (curConf == CONF_MAX) ? curConf : curConf + CONF_W'(1);
    else            nextConf = (curConf == '0)       ? curConf : curConf - CONF_W'(1);
  end

  assign emitOk    = hit && (nextConf >= cfgThreshold);
  assign crossPage = cfgPageStop &&
                     (curAddr[ADDR_W-1:PAGE_LG] != baseAddr[ADDR_W-1:PAGE_LG]);
  assign pfAddr    = curAddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++) begin
        tabValid[b] <= '0;
        for (int i = 0; i < ENTRIES; i++) begin
          tabPc[b][i]     <= '0;
          tabLast[b][i]   <= '0;
          tabStride[b][i] <= '0;
          tabConf[b][i]   <= '0;
        end
      end
      baseAddr  <= '0;
      strideReg <= '0;
      curAddr   <= '0;
      spanCount <= '0;
    end else begin
      if (strb.load) begin
        if (hit) begin
          tabLast[bankSel][hitIdx]   <= blkAddr;
          tabStride[bankSel][hitIdx] <= newStride;
          tabConf[bankSel][hitIdx]   <= nextConf;
          strideReg                  <= newStride;
          curAddr                    <= blkAddr + newStride;
        end else begin
          tabValid[bankSel][victIdx]  <= 1'b1;
          tabPc[bankSel][victIdx]     <= trainPc;
          tabLast[bankSel][victIdx]   <= blkAddr;
          tabStride[bankSel][victIdx] <= '0;
          tabConf[bankSel][victIdx]   <= '0;
          strideReg                   <= '0;
          curAddr                     <= blkAddr;
        end
        baseAddr <= blkAddr;
      end else if (strb.step) begin
        curAddr <= curAddr + strideReg;
      end
      if (strb.spanAdd) spanCount <= spanCount + CNT_W'(remain);
    end
  end

endmodule

// File: rtl/spt_control.sv
module spt_control
  import spt_pkg::*;
#(
  parameter int DEG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trainValid,
  output logic             trainReady,
  input  logic [DEG_W-1:0] cfgDegree,
  input  logic             emitOk,
  input  logic             crossPage,
  output logic             pfValid,
  input  logic             pfReady,
  output sptStrobes_t      strb,
  output logic [DEG_W-1:0] remain
);

  sptState_t        state;
  logic [DEG_W-1:0] dCnt;
  logic [DEG_W-1:0] degHeld;

  assign trainReady   = (state == ST_IDLE);
  assign pfValid      = (state == ST_EMIT) && !crossPage;
  assign strb.load    = (state == ST_IDLE) && trainValid;
  assign strb.step    = pfValid && pfReady;
  assign strb.spanAdd = (state == ST_EMIT) && crossPage;
  assign remain       = degHeld - dCnt + DEG_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      dCnt    <= '0;
      degHeld <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strb.load) begin
            degHeld <= cfgDegree;
            dCnt    <= DEG_W'(1);
            if (emitOk && cfgDegree != '0) state <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (crossPage) begin
            state <= ST_IDLE;
          end else if (pfReady) begin
            if (dCnt == degHeld) state <= ST_IDLE;
            else                 dCnt  <= dCnt + DEG_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stride_prefetch_table.sv
module stride_prefetch_table
  import spt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PC_W    = 32,
  parameter int ID_W    = 1,
  parameter int ENTRIES = 4,
  parameter int CONF_W  = 2,
  parameter int DEG_W   = 3,
  parameter int BLK_LG  = 6,
  parameter int PAGE_LG = 12,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trainValid,
  output logic              trainReady,
  input  logic [ADDR_W-1:0] trainAddr,
  input  logic [PC_W-1:0]   trainPc,
  input  logic [ID_W-1:0]   trainId,
  input  logic              cfgPerRequester,
  input  logic              cfgPageStop,
  input  logic [DEG_W-1:0]  cfgDegree,
  input  logic [CONF_W-1:0] cfgThreshold,
  output logic              pfValid,
  input  logic              pfReady,
  output logic [ADDR_W-1:0] pfAddr,
  output logic [CNT_W-1:0]  spanCount
);

  sptStrobes_t      strb;
  logic [DEG_W-1:0] remain;
  logic             emitOk;
  logic             crossPage;

  spt_control #(.DEG_W(DEG_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .trainValid(trainValid),
    .trainReady(trainReady),
    .cfgDegree (cfgDegree),
    .emitOk    (emitOk),
    .crossPage (crossPage),
    .pfValid   (pfValid),
    .pfReady   (pfReady),
    .strb      (strb),
    .remain    (remain)
  );

  spt_datapath #(
    .ADDR_W (ADDR_W),
    .PC_W   (PC_W),
    .ID_W   (ID_W),
    .ENTRIES(ENTRIES),
    .CONF_W (CONF_W),
    .DEG_W  (DEG_W),
    .BLK_LG (BLK_LG),
    .PAGE_LG(PAGE_LG),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strb           (strb),
    .remain         (remain),
    .trainAddr      (trainAddr),
    .trainPc        (trainPc),
    .trainId        (trainId),
    .cfgPerRequester(cfgPerRequester),
    .cfgPageStop    (cfgPageStop),
    .cfgThreshold   (cfgThreshold),
    .emitOk         (emitOk),
    .crossPage      (crossPage),
    .pfAddr         (pfAddr),
    .spanCount      (spanCount)
  );

endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
  parameter int ADDR_W  = 32,
  parameter int DEG_W   = 3,
  parameter int BLK_LG  = 6,
  parameter int PAGE_LG = 12,
  parameter int CNT_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trainValid,
  input logic              trainReady,
  input logic [ADDR_W-1:0] trainAddr,
  input logic              cfgPageStop,
  input logic [DEG_W-1:0]  cfgDegree,
  input logic              pfValid,
  input logic              pfReady,
  input logic [ADDR_W-1:0] pfAddr,
  input logic [CNT_W-1:0]  spanCount
);

  logic [ADDR_W-PAGE_LG-1:0] trigPage;
  logic [DEG_W-1:0]          degHold;
  logic [DEG_W:0]            emitCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trigPage <= '0;
      degHold  <= '0;
      emitCnt  <= '0;
    end else if (trainValid && trainReady) begin
      trigPage <= trainAddr[ADDR_W-1:PAGE_LG];
      degHold  <= cfgDegree;
      emitCnt  <= '0;
    end else if (pfValid && pfReady) begin
      emitCnt <= emitCnt + 1'b1;
    end
  end

  AST_PF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pfValid |-> pfAddr[BLK_LG-1:0] == '0); // R1

  AST_DEGREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pfValid |-> emitCnt < {1'b0, degHold}); // R4

  AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pfValid && !pfReady |=> pfValid && $stable(pfAddr)); // R5

  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    pfValid |-> !trainReady); // R5

  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    pfValid && cfgPageStop |-> pfAddr[ADDR_W-1:PAGE_LG] == trigPage); // R6

  AST_SPAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pfValid |=> $stable(spanCount)); // R6

endmodule

bind stride_prefetch_table spt_checker #(
  .ADDR_W (ADDR_W),
  .DEG_W  (DEG_W),
  .BLK_LG (BLK_LG),
  .PAGE_LG(PAGE_LG),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trainValid (trainValid),
  .trainReady (trainReady),
  .trainAddr  (trainAddr),
  .cfgPageStop(cfgPageStop),
  .cfgDegree  (cfgDegree),
  .pfValid    (pfValid),
  .pfReady    (pfReady),
  .pfAddr     (pfAddr),
  .spanCount  (spanCount)
);

// File: tb/stride_prefetch_table_bench.sv
module stride_prefetch_table_bench;

  localparam int ADDR_W  = 32;
  localparam int PC_W    = 32;
  localparam int ID_W    = 1;
  localparam int ENTRIES = 4;
  localparam int CONF_W  = 2;
  localparam int DEG_W   = 3;
  localparam int BLK_LG  = 6;
  localparam int PAGE_LG = 9;
  localparam int CNT_W   = 16;
  localparam int BANKS   = 1 << ID_W;
  localparam int CONF_MAX = (1 << CONF_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              trainValid = 1'b0;
  logic              trainReady;
  logic [ADDR_W-1:0] trainAddr = '0;
  logic [PC_W-1:0]   trainPc = '0;
  logic [ID_W-1:0]   trainId = '0;
  logic              cfgPerRequester = 1'b0;
  logic              cfgPageStop = 1'b0;
  logic [DEG_W-1:0]  cfgDegree = 3'd3;
  logic [CONF_W-1:0] cfgThreshold = 2'd1;
  logic              pfValid;
  logic              pfReady = 1'b0;
  logic [ADDR_W-1:0] pfAddr;
  logic [CNT_W-1:0]  spanCount;

  always #4 clk = ~clk;

  stride_prefetch_table #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .ID_W(ID_W), .ENTRIES(ENTRIES),
    .CONF_W(CONF_W), .DEG_W(DEG_W), .BLK_LG(BLK_LG), .PAGE_LG(PAGE_LG),
    .CNT_W(CNT_W)
  ) u_stride_prefetch_table (
    .clk(clk), .rst_n(rst_n), .trainValid(trainValid), .trainReady(trainReady),
    .trainAddr(trainAddr), .trainPc(trainPc), .trainId(trainId),
    .cfgPerRequester(cfgPerRequester), .cfgPageStop(cfgPageStop),
    .cfgDegree(cfgDegree), .cfgThreshold(cfgThreshold),
    .pfValid(pfValid), .pfReady(pfReady), .pfAddr(pfAddr), .spanCount(spanCount)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // reference model state, written from the requirements
  bit              mValid  [BANKS][ENTRIES];
  logic [PC_W-1:0] mPc     [BANKS][ENTRIES];
  logic [31:0]     mLast   [BANKS][ENTRIES];
  logic [31:0]     mStride [BANKS][ENTRIES];
  int              mConf   [BANKS][ENTRIES];
  logic [31:0]     expQ [8];
  int              expN;
  logic [CNT_W-1:0] mSpan = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void modelTrain(input logic [31:0] addr, input logic [PC_W-1:0] pc,
                                     input logic [ID_W-1:0] id);
    logic [31:0] blk, ns, a;
    int b, hitI, v, bestC;
    blk  = addr & ~32'((1 << BLK_LG) - 1);
    b    = cfgPerRequester ? int'(id) : 0;
    hitI = -1;
    expN = 0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (mValid[b][i] && mPc[b][i] == pc) hitI = i;
    if (hitI >= 0) begin
      ns = blk - mLast[b][hitI];
      if (ns == mStride[b][hitI]) begin
        if (mConf[b][hitI] < CONF_MAX) mConf[b][hitI]++;
      end else begin
        mStride[b][hitI] = ns;
        if (mConf[b][hitI] > 0) mConf[b][hitI]--;
      end
      mLast[b][hitI] = blk;
      if (mConf[b][hitI] >= int'(cfgThreshold)) begin
        a = blk;
        for (int d = 1; d <= int'(cfgDegree); d++) begin
          a = a + ns;
          if (cfgPageStop && a[31:PAGE_LG] != blk[31:PAGE_LG]) begin
            mSpan = mSpan + CNT_W'(int'(cfgDegree) - d + 1);
            break;
          end
          expQ[expN] = a;
          expN++;
        end
      end
    end else begin
      v = -1;
      for (int i = 0; i < ENTRIES; i++) if (!mValid[b][i] && v < 0) v = i;
      if (v < 0) begin
        v = 0; bestC = mConf[b][0];
        for (int i = 1; i < ENTRIES; i++)
          if (mConf[b][i] < bestC) begin bestC = mConf[b][i]; v = i; end
      end
      mValid[b][v] = 1'b1; mPc[b][v] = pc; mLast[b][v] = blk;
      mStride[b][v] = '0; mConf[b][v] = 0;
    end
  endfunction

  task automatic doTrain(input logic [31:0] addr, input logic [PC_W-1:0] pc,
                         input logic [ID_W-1:0] id, input string tag);
    int got;
    modelTrain(addr, pc, id);
    @(negedge clk);
    trainValid = 1'b1; trainAddr = addr; trainPc = pc; trainId = id;
    @(negedge clk);
    trainValid = 1'b0;
    got = 0;
    while (!trainReady) begin
      pfReady = ($urandom % 4) != 0;
      if (pfValid && pfReady) begin
        if (got < expN)
          check(pfAddr == expQ[got], {tag, " R4 address"}, pfAddr, expQ[got]);
        got++;
      end
      @(negedge clk);
    end
    pfReady = 1'b0;
    check(got == expN, {tag, " R4 count"}, 32'(got), 32'(expN));
    check(spanCount == mSpan, {tag, " R6 span"}, 32'(spanCount), 32'(mSpan));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  logic [31:0] rLast [6];

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int b = 0; b < BANKS; b++)
      for (int i = 0; i < ENTRIES; i++) begin
        mValid[b][i] = 0; mPc[b][i] = '0; mLast[b][i] = '0;
        mStride[b][i] = '0; mConf[b][i] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(trainReady == 1'b1, "R9 trainReady", 32'(trainReady), 1);
    check(pfValid == 1'b0, "R9 pfValid", 32'(pfValid), 0);
    check(spanCount == '0, "R9 spanCount", 32'(spanCount), 0);

    // R7: first sight allocates, no emission; R1 unaligned inputs
    doTrain(32'h0000_1005, 32'h100, 0, "R7");
    // R3: stride replaced, confidence held at 0
    doTrain(32'h0000_1047, 32'h100, 0, "R3");
    // R2 hit with matching stride, R4 emission of three
    doTrain(32'h0000_1080, 32'h100, 0, "R2");
    doTrain(32'h0000_10C0, 32'h100, 0, "R4");
    doTrain(32'h0000_1100, 32'h100, 0, "R3");   // saturate
    doTrain(32'h0000_1140, 32'h100, 0, "R3");
    // R6: page stop on, crossing within the run
    cfgPageStop = 1'b1; cfgDegree = 3'd7;
    doTrain(32'h0000_1180, 32'h100, 0, "R6");
    // negative stride crossing down
    doTrain(32'h0000_1140, 32'h100, 0, "R6");
    doTrain(32'h0000_1100, 32'h100, 0, "R6");
    cfgPageStop = 1'b0;
    doTrain(32'h0000_10C0, 32'h100, 0, "R6");
    // R4: degree 0 emits nothing
    cfgDegree = 3'd0;
    doTrain(32'h0000_1080, 32'h100, 0, "R4");
    // R4: threshold above confidence
    cfgDegree = 3'd4; cfgThreshold = 2'd3;
    doTrain(32'h0000_2000, 32'h100, 0, "R4");
    cfgThreshold = 2'd1;
    // R7: fill table then replace least confident
    doTrain(32'h0000_3000, 32'h200, 0, "R7");
    doTrain(32'h0000_4000, 32'h300, 0, "R7");
    doTrain(32'h0000_5000, 32'h400, 0, "R7");
    doTrain(32'h0000_6000, 32'h500, 0, "R7");
    doTrain(32'h0000_1000, 32'h100, 0, "R7");
    // R8: per-requester banks
    cfgPerRequester = 1'b1;
    doTrain(32'h0000_7000, 32'h600, 1, "R8");
    doTrain(32'h0000_7040, 32'h600, 1, "R8");
    doTrain(32'h0000_7080, 32'h600, 1, "R8");
    doTrain(32'h0000_70C0, 32'h600, 0, "R8");
    cfgPerRequester = 1'b0;

    // constrained random phase
    for (int k = 0; k < 6; k++) rLast[k] = 32'h0001_0000 * (k + 1);
    for (int n = 0; n < 400; n++) begin
      int p;
      logic [31:0] st;
      p = $urandom % 6;
      case ($urandom % 5)
        0: st = 32'h40;
        1: st = -32'h40;
        2: st = 32'h80;
        3: st = -32'hC0;
        default: st = ($urandom % 16) << 4;
      endcase
      if (($urandom % 4) == 0) st = st * 2;
      rLast[p] = rLast[p] + st;
      if (($urandom % 16) == 0) begin
        cfgPageStop     = $urandom % 2;
        cfgPerRequester = $urandom % 2;
        cfgDegree       = DEG_W'($urandom % 8);
        cfgThreshold    = CONF_W'($urandom % 4);
      end
      doTrain(rLast[p] | ($urandom % 64), 32'h1000 + 32'(p * 4),
              ID_W'($urandom % 2), "rand");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule